// File: doc/BRIEF.md
# Dual-Mode SDR/DDR Data Phase Sequencer

This block sits on the controller side of a synchronous DRAM interface. For each accepted read or write command, it produces the control windows for the data phase. The memory may be run at single data rate or at double data rate, and a configuration input selects which. From the mode, a CAS latency and a burst length, the sequencer works out these windows:

- when read data must be captured;
- when write data is driven;
- when the write strobe is driven, including its one-half-clock preamble.

Every window is timed in half-clock slots, so a CAS latency of two and a half clocks lands on the correct half cycle. Each window output is two bits wide: bit 0 covers the first half of a clock period (after the rising edge) and bit 1 covers the second half. Slots are counted from the launch cycle. The launch cycle is the clock cycle that follows the rising edge at which the command was accepted. Slot 2k+p is half p of the k-th cycle after launch.

The configuration is checked continuously. A latency or burst code that the selected mode does not allow raises an error flag, and commands are refused for as long as the flag is set. A command that arrives during a data phase is refused, with one exception: a command in the final cycle of the phase is accepted, so that its launch cycle directly follows the phase.

Top module: `sdr_ddr_seq`

## Requirements
- R1: `cfg_cl` gives the CAS latency in half clocks. `cfg_bl` gives the burst length as a power of two (0=1, 1=2, 2=4, 3=8). In double-rate mode (`cfg_ddr`=1), the legal latency codes are 4, 5 and 6, and the legal burst codes are 1 to 3. In single-rate mode, the legal latency codes are 4 and 6, and the legal burst codes are 0 to 3. `cfg_err` is high exactly when the setting is illegal.
- R2: While `cfg_err` is high, `cmd_valid` is not acknowledged. No window and no `busy` follows from it.
- R3: `cmd_ack` is high when `cmd_valid` is high, the setting is legal, and either `busy` is low or the current cycle is the last cycle of the data phase. A command that is not acknowledged leaves the running data phase unchanged.
- R4: The read window `rd_win` covers the slots from the CAS latency up to, but not including, the latency plus the burst length. Burst length counts slots in double-rate mode and clocks in single-rate mode.
- R5: The write data window `wr_de` starts at slot 2 in double-rate mode and at slot 0 in single-rate mode. Its length follows the same rule as in R4.
- R6: For a double-rate write, `wr_dqs_en` covers slot 1 through the end of the data window, and `wr_pre` marks slot 1 only. Both stay low for single-rate writes and for reads.
- R7: `rd_cap_dqs` is high in cycles where the read window is active in double-rate mode, meaning capture uses the returned strobe. In single-rate mode it stays low, meaning capture uses the clock.
- R8: `busy` is high from the launch cycle through the last cycle that contains a slot of the data window.
- R9: After reset, and until two clock edges after reset release, all outputs except `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cfg_ddr | input | 1 | 1 = double data rate, 0 = single data rate |
| cfg_cl | input | 3 | CAS latency in half clocks |
| cfg_bl | input | 2 | Burst length code (log2 of the length) |
| cmd_ack | output | 1 | Command accepted at this edge |
| cfg_err | output | 1 | Illegal configuration for the selected mode |
| busy | output | 1 | Data phase in progress |
| rd_win | output | 2 | Read capture window, per half clock |
| rd_cap_dqs | output | 1 | Capture read data on the returned strobe |
| wr_de | output | 2 | Write data enable, per half clock |
| wr_dqs_en | output | 2 | Write strobe drive enable, per half clock |
| wr_pre | output | 2 | Write strobe preamble slot, per half clock |

## Verification
The bench builds the block with its default parameters: a three-bit latency code and a two-bit burst code. These reach every legal latency, including the half-clock case, and every burst length up to eight in both modes. They also reach illegal codes on both sides of the legal ranges. The longest data phase reachable with these defaults is 22 slots, for a single-rate read at latency 3 with a burst of 8. This lets the bench check the widest window, as well as the back-to-back acceptance in the last cycle of a phase followed by a mode-specific preamble.

// File: rtl/sdr_ddr_seq_pkg.sv
package sdr_ddr_seq_pkg;

  // Legal CAS latency range in half clocks, shared by both modes
  localparam int CL_MIN_H = 4;
  localparam int CL_MAX_H = 6;
  // Double-rate write data starts one clock (two slots) after launch
  localparam int DDR_WR_START = 2;
  // Double-rate strobe preamble occupies the slot before the first beat
  localparam int DDR_PRE_SLOT = 1;

  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;

endpackage

// File: rtl/seq_cfg_check.sv
module seq_cfg_check
  import sdr_ddr_seq_pkg::*;
#(
  parameter int CLW = 3,
  parameter int BLW = 2
) (
  input  logic           ddr,
  input  logic [CLW-1:0] cl,
  input  logic [BLW-1:0] bl,
  output logic           err
);

  logic cl_in_range;
  logic cl_ok;
  logic bl_ok;

  always_comb begin
    cl_in_range = (int'(cl) >= CL_MIN_H) && (int'(cl) <= CL_MAX_H);
    // Single rate accepts whole-clock latencies only
    cl_ok       = cl_in_range && (ddr || !cl[0]);
    // Double rate has no single-beat burst
    bl_ok       = !ddr || (bl != '0);
    err         = !(cl_ok && bl_ok);
  end

endmodule

// File: rtl/seq_phase_win.sv
module seq_phase_win #(
  parameter int TW = 5
) (
  input  logic          en,
  input  logic [TW-1:0] t,
  input  logic [TW-1:0] first,
  input  logic [TW-1:0] stop,
  output logic [1:0]    win
);

  for (genvar p = 0; p < 2; p++) begin : g_phase
    logic [TW-1:0] slot;
    assign slot   = t + TW'(p);
    assign win[p] = en && (slot >= first) && (slot < stop);
  end

endmodule

// File: rtl/sdr_ddr_seq.sv
module sdr_ddr_seq
  import sdr_ddr_seq_pkg::*;
#(
  parameter int CLW = 3,
  parameter int BLW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic           cmd_write,
  input  logic           cfg_ddr,
  input  logic [CLW-1:0] cfg_cl,
  input  logic [BLW-1:0] cfg_bl,
  output logic           cmd_ack,
  output logic           cfg_err,
  output logic           busy,
  output logic [1:0]     rd_win,
  output logic           rd_cap_dqs,
  output logic [1:0]     wr_de,
  output logic [1:0]     wr_dqs_en,
  output logic [1:0]     wr_pre
);

  localparam int MAX_BL  = 1 << ((1 << BLW) - 1);
  localparam int END_MAX = (1 << CLW) - 1 + 2 * MAX_BL;
  localparam int TW      = $clog2(END_MAX + 3);

  // Reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run = rst_sync_q[1];

  seq_cfg_check #(.CLW(CLW), .BLW(BLW)) u_cfg (
    .ddr (cfg_ddr),
    .cl  (cfg_cl),
    .bl  (cfg_bl),
    .err (cfg_err)
  );

  // Phase state
  logic          act_q, act_d;
  logic [TW-1:0] t_q, t_d;
  op_e           op_q, op_d;
  logic          ddr_q, ddr_d;
  logic [TW-1:0] cl_q, cl_d;
  logic [TW-1:0] len_q, len_d;
  logic          st_en;

  logic [TW-1:0] len_in;
  logic [TW-1:0] rd_stop;
  logic [TW-1:0] wd_first;
  logic [TW-1:0] wd_stop;
  logic [TW-1:0] ph_stop;
  logic          last;

  always_comb begin
    len_in   = cfg_ddr ? (TW'(1) << cfg_bl) : (TW'(2) << cfg_bl);
    rd_stop  = cl_q + len_q;
    wd_first = ddr_q ? TW'(DDR_WR_START) : '0;
    wd_stop  = wd_first + len_q;
    ph_stop  = (op_q == OP_WRITE) ? wd_stop : rd_stop;
    last     = act_q && ((t_q + TW'(2)) >= ph_stop);
    cmd_ack  = run && cmd_valid && !cfg_err && (!act_q || last);
  end

  always_comb begin
    act_d = act_q;
    t_d   = t_q;
    op_d  = op_q;
    ddr_d = ddr_q;
    cl_d  = cl_q;
    len_d = len_q;
    st_en = 1'b0;
    if (cmd_ack) begin
      st_en = 1'b1;
      act_d = 1'b1;
      t_d   = '0;
      op_d  = cmd_write ? OP_WRITE : OP_READ;
      ddr_d = cfg_ddr;
      cl_d  = TW'(cfg_cl);
      len_d = len_in;
    end else if (act_q) begin
      st_en = 1'b1;
      act_d = !last;
      t_d   = last ? '0 : t_q + TW'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      t_q   <= '0;
      op_q  <= OP_READ;
      ddr_q <= 1'b0;
      cl_q  <= '0;
      len_q <= '0;
    end else if (st_en) begin
      act_q <= act_d;
      t_q   <= t_d;
      op_q  <= op_d;
      ddr_q <= ddr_d;
      cl_q  <= cl_d;
      len_q <= len_d;
    end
  end

  logic en_rd, en_wr, en_dqs;
  assign en_rd  = act_q && (op_q == OP_READ);
  assign en_wr  = act_q && (op_q == OP_WRITE);
  assign en_dqs = en_wr && ddr_q;

  seq_phase_win #(.TW(TW)) u_rd_win (
    .en (en_rd), .t (t_q), .first (cl_q), .stop (rd_stop), .win (rd_win)
  );

  seq_phase_win #(.TW(TW)) u_wd_win (
    .en (en_wr), .t (t_q), .first (wd_first), .stop (wd_stop), .win (wr_de)
  );

  seq_phase_win #(.TW(TW)) u_dqs_win (
    .en (en_dqs), .t (t_q), .first (TW'(DDR_PRE_SLOT)), .stop (wd_stop),
    .win (wr_dqs_en)
  );

  seq_phase_win #(.TW(TW)) u_pre_win (
    .en (en_dqs), .t (t_q), .first (TW'(DDR_PRE_SLOT)),
    .stop (TW'(DDR_PRE_SLOT + 1)), .win (wr_pre)
  );

  assign busy       = act_q;
  assign rd_cap_dqs = ddr_q && (rd_win != 2'b00);

endmodule

// File: rtl/sdr_ddr_seq_chk.sv
module sdr_ddr_seq_chk #(
  parameter int CLW = 3,
  parameter int BLW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cfg_ddr,
  input logic [CLW-1:0] cfg_cl,
  input logic [BLW-1:0] cfg_bl,
  input logic           cmd_ack,
  input logic           cfg_err,
  input logic           busy,
  input logic [1:0]     rd_win,
  input logic           rd_cap_dqs,
  input logic [1:0]     wr_de,
  input logic [1:0]     wr_dqs_en,
  input logic [1:0]     wr_pre
);

  assert_legal_ddr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ddr && cfg_cl == CLW'(5) && cfg_bl == BLW'(2)) |-> !cfg_err);

  assert_err_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && cmd_valid) |-> !cmd_ack);

  assert_ack_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> busy);

  assert_rd_wr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !((rd_win != 2'b00) && (wr_de != 2'b00)));

  assert_pre_before_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pre != 2'b00) |-> (wr_dqs_en[1] && wr_de == 2'b00));

  assert_cap_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap_dqs |-> (rd_win != 2'b00));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_win == 2'b00 && wr_de == 2'b00 && wr_dqs_en == 2'b00));

endmodule

bind sdr_ddr_seq sdr_ddr_seq_chk #(.CLW(CLW), .BLW(BLW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cfg_ddr    (cfg_ddr),
  .cfg_cl     (cfg_cl),
  .cfg_bl     (cfg_bl),
  .cmd_ack    (cmd_ack),
  .cfg_err    (cfg_err),
  .busy       (busy),
  .rd_win     (rd_win),
  .rd_cap_dqs (rd_cap_dqs),
  .wr_de      (wr_de),
  .wr_dqs_en  (wr_dqs_en),
  .wr_pre     (wr_pre)
);

// File: tb/sdr_ddr_seq_tb.sv
module sdr_ddr_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_write = 1'b0;
  logic       cfg_ddr = 1'b1;
  logic [2:0] cfg_cl = 3'd4;
  logic [1:0] cfg_bl = 2'd2;
  logic       cmd_ack, cfg_err, busy, rd_cap_dqs;
  logic [1:0] rd_win, wr_de, wr_dqs_en, wr_pre;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sdr_ddr_seq u_dut (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_write (cmd_write),
    .cfg_ddr (cfg_ddr), .cfg_cl (cfg_cl), .cfg_bl (cfg_bl),
    .cmd_ack (cmd_ack), .cfg_err (cfg_err), .busy (busy), .rd_win (rd_win),
    .rd_cap_dqs (rd_cap_dqs), .wr_de (wr_de), .wr_dqs_en (wr_dqs_en),
    .wr_pre (wr_pre)
  );

  // {wr, ddr, cl, bl, err, first slot, stop slot}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd4, 2'd2, 1'b0, 5'd4, 5'd8},
    {1'b0, 1'b1, 3'd5, 2'd3, 1'b0, 5'd5, 5'd13},
    {1'b0, 1'b1, 3'd6, 2'd1, 1'b0, 5'd6, 5'd8},
    {1'b0, 1'b0, 3'd4, 2'd0, 1'b0, 5'd4, 5'd6},
    {1'b0, 1'b0, 3'd6, 2'd3, 1'b0, 5'd6, 5'd22},
    {1'b1, 1'b1, 3'd4, 2'd2, 1'b0, 5'd2, 5'd6},
    {1'b1, 1'b1, 3'd5, 2'd1, 1'b0, 5'd2, 5'd4},
    {1'b1, 1'b0, 3'd4, 2'd3, 1'b0, 5'd0, 5'd16},
    {1'b1, 1'b0, 3'd6, 2'd0, 1'b0, 5'd0, 5'd2},
    {1'b0, 1'b0, 3'd5, 2'd1, 1'b1, 5'd0, 5'd0},
    {1'b0, 1'b1, 3'd4, 2'd0, 1'b1, 5'd0, 5'd0},
    {1'b1, 1'b1, 3'd7, 2'd2, 1'b1, 5'd0, 5'd0},
    {1'b0, 1'b0, 3'd3, 2'd1, 1'b1, 5'd0, 5'd0}
  };

  task automatic chk(input string req, input string what,
                     input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [1:0] exp_win(input int k, input int s, input int e);
    for (int p = 0; p < 2; p++)
      exp_win[p] = ((2 * k + p) >= s) && ((2 * k + p) < e);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [17:0] v;
    logic [1:0]  ew;
    // R9: reset state
    repeat (2) @(negedge clk);
    chk("R9", "busy in reset", {3'b0, busy}, 4'h0);
    chk("R9", "windows in reset", {rd_win, wr_de}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b1;
    #1;
    chk("R9", "ack before sync release", {3'b0, cmd_ack}, 4'h0);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      cmd_write = v[17];
      cfg_ddr   = v[16];
      cfg_cl    = v[15:13];
      cfg_bl    = v[12:11];
      cmd_valid = 1'b1;
      #1;
      chk("R1", "cfg_err", {3'b0, cfg_err}, {3'b0, v[10]});
      chk("R3", "cmd_ack", {3'b0, cmd_ack}, {3'b0, !v[10]});
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int k = 0; k < 12; k++) begin
        if (v[10]) begin
          chk("R2", "busy after refused cmd", {3'b0, busy}, 4'h0);
          chk("R2", "windows after refused cmd", {rd_win, wr_de}, 4'h0);
        end else begin
          ew = exp_win(k, int'(v[9:5]), int'(v[4:0]));
          chk("R4", "rd_win", {2'b0, rd_win}, {2'b0, v[17] ? 2'b00 : ew});
          chk("R5", "wr_de", {2'b0, wr_de}, {2'b0, v[17] ? ew : 2'b00});
          chk("R6", "wr_dqs_en", {2'b0, wr_dqs_en},
              {2'b0, (v[17] && v[16]) ? exp_win(k, 1, int'(v[4:0])) : 2'b00});
          chk("R6", "wr_pre", {2'b0, wr_pre},
              {2'b0, (v[17] && v[16]) ? exp_win(k, 1, 2) : 2'b00});
          chk("R7", "rd_cap_dqs", {3'b0, rd_cap_dqs},
              {3'b0, !v[17] && v[16] && (ew != 2'b00)});
          chk("R8", "busy", {3'b0, busy}, {3'b0, (2 * k) < int'(v[4:0])});
        end
        @(negedge clk);
      end
    end

    // R3: refusal mid-phase and back-to-back acceptance in the last cycle
    cmd_write = 1'b0; cfg_ddr = 1'b1; cfg_cl = 3'd4; cfg_bl = 2'd2;
    cmd_valid = 1'b1;
    #1;
    chk("R3", "first ack", {3'b0, cmd_ack}, 4'h1);
    @(negedge clk);                       // launch cycle k=0
    cmd_valid = 1'b0;
    @(negedge clk);                       // k=1
    cmd_write = 1'b1; cmd_valid = 1'b1;
    #1;
    chk("R3", "mid-phase refusal", {3'b0, cmd_ack}, 4'h0);
    cmd_valid = 1'b0;
    @(negedge clk);                       // k=2
    chk("R3", "read intact k2", {2'b0, rd_win}, 4'h3);
    @(negedge clk);                       // k=3, last cycle
    chk("R3", "read intact k3", {2'b0, rd_win}, 4'h3);
    cmd_valid = 1'b1;
    #1;
    chk("R3", "back-to-back ack", {3'b0, cmd_ack}, 4'h1);
    @(negedge clk);                       // new launch
    cmd_valid = 1'b0;
    chk("R3", "b2b busy", {3'b0, busy}, 4'h1);
    chk("R6", "b2b preamble", {2'b0, wr_pre}, 4'h2);
    chk("R3", "b2b read ended", {2'b0, rd_win}, 4'h0);
    @(negedge clk);
    chk("R5", "b2b write data", {2'b0, wr_de}, 4'h3);
    @(negedge clk);
    chk("R5", "b2b write data end", {2'b0, wr_de}, 4'h3);
    @(negedge clk);
    chk("R8", "b2b idle", {3'b0, busy}, 4'h0);

    // R9: asynchronous reset mid-phase
    cmd_write = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R9", "busy cleared by reset", {3'b0, busy}, 4'h0);
    finish_run();
  end

endmodule